// File: doc/BRIEF.md
# Electronic Dice Roller

The block rolls a six-sided die and lights a seven-dot die face. Its state is a three-stage twisted-ring counter: the inverted last stage feeds the first stage, so the counter passes through six codes in a fixed loop. While the roll input is held high, the counter steps on every clock edge. The clock is fast compared with a person pressing a button, so the code left when the button is released cannot be predicted. When roll goes low, the counter stops, and the code it holds is the result.

The three counter bits are not converted to a binary count before the dots are lit. Small logic turns them into four shared dot groups: the centre dot, two pairs of opposite corners, and the pair of middle-side dots. Every face is one combination of these groups. The dots are arranged as a left column of three, a right column of three and one centre dot. A face value from 1 to 6 and a valid flag are also brought out so that a result can be checked.

Top module: `dice_roller_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, the counter is loaded with code 000 (face 6) and `valid_o` goes low. This happens even if `roll_i` is high in the same cycle.
- R2: When `roll_i` is high at an edge, the counter moves one step. The stage codes (s1,s2,s3) run in the loop 000, 100, 110, 111, 011, 001 and then back to 000. These codes show faces 6, 4, 2, 1, 3 and 5.
- R3: When `roll_i` is low at an edge, the counter and every output keep their values.
- R4: `valid_o` is low after an edge at which `roll_i` was high. It is high after an edge at which `roll_i` was low and `rst` was low.
- R5: `face_o` always gives the face shown, as a binary number from 1 to 6. The unused codes 010 and 101 are sent to 000 at the next edge.
- R6: The centre dot, `dots_o[6]`, is lit exactly on faces 1, 3 and 5. It follows stage s3.
- R7: The corner pair `dots_o[0]` (left top) and `dots_o[5]` (right bottom) is lit on every face except 1. It is the NAND of all three stages.
- R8: The corner pair `dots_o[2]` (left bottom) and `dots_o[3]` (right top) is lit exactly on faces 4, 5 and 6. It follows the inverse of s2.
- R9: The middle-side pair `dots_o[1]` and `dots_o[4]` is lit only on face 6. It is lit when all three stages are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| roll_i | input | 1 | High to run the counter, low to stop it and keep the result |
| dots_o | output | 7 | Die dots: [0] left top, [1] left middle, [2] left bottom, [3] right top, [4] right middle, [5] right bottom, [6] centre |
| face_o | output | 3 | Face value from 1 to 6 |
| valid_o | output | 1 | The held face is a finished roll |

## Verification
Reset and a counter step can both be requested at the same edge. The bench raises `rst` while `roll_i` is also high, in the middle of a roll. It then checks that the outputs show face 6 with `valid_o` low, not the next code in the loop. A release of roll and the rise of `valid_o` are also seen in the same sampled cycle. After the release edge, the bench checks that the face is frozen at the value its own step model predicts and that the flag is already high.

// File: rtl/dice_pkg.sv
package dice_pkg;

    localparam int NUM_DOTS   = 7;
    localparam int FACE_W     = 3;

    // dot positions on the face
    localparam int DOT_LT = 0;
    localparam int DOT_LM = 1;
    localparam int DOT_LB = 2;
    localparam int DOT_RT = 3;
    localparam int DOT_RM = 4;
    localparam int DOT_RB = 5;
    localparam int DOT_CC = 6;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } ring_t;

    typedef struct packed {
        logic centre;    // odd faces
        logic diag_main; // all but face 1
        logic diag_anti; // faces 4, 5, 6
        logic mids;      // face 6 only
    } base_t;

    localparam ring_t RING_HOME = '{s1: 1'b0, s2: 1'b0, s3: 1'b0};

    function automatic logic ring_unused(input ring_t r);
        return (r.s1 != r.s2) && (r.s2 != r.s3) && (r.s1 == r.s3);
    endfunction

    function automatic ring_t ring_step(input ring_t r);
        ring_t n;
        n.s1 = ~r.s3;
        n.s2 = r.s1;
        n.s3 = r.s2;
        return n;
    endfunction

    function automatic logic [FACE_W-1:0] ring_face(input ring_t r);
        logic [FACE_W-1:0] f;
        unique case ({r.s1, r.s2, r.s3})
            3'b000:  f = 3'd6;
            3'b100:  f = 3'd4;
            3'b110:  f = 3'd2;
            3'b111:  f = 3'd1;
            3'b011:  f = 3'd3;
            3'b001:  f = 3'd5;
            default: f = 3'd0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/dice_ring_counter.sv
module dice_ring_counter
    import dice_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    output ring_t state
);

    ring_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RING_HOME;
        end else if (ring_unused(st_q)) begin
            st_q <= RING_HOME;
        end else if (run) begin
            st_q <= ring_step(st_q);
        end
    end

    assign state = st_q;

    // R3: stopped counter keeps its code
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(st_q));

    // R2: a running twisted ring always changes code
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        run |=> (st_q != $past(st_q)));

    // R5: only the six loop codes are ever held
    p_legal_r5: assert property (@(posedge clk) disable iff (rst)
        !ring_unused(st_q));

endmodule

// File: rtl/dice_base_decode.sv
module dice_base_decode
    import dice_pkg::*;
(
    input  ring_t state,
    output base_t base
);

    always_comb begin
        base.centre    = state.s3;
        base.diag_anti = ~state.s2;
        base.diag_main = ~(state.s1 & state.s2 & state.s3);
        base.mids      = ~state.s1 & ~state.s2 & ~state.s3;
    end

    // R9: the middle pair only appears together with both corner pairs
    always_comb begin
        if (base.mids) begin
            a_mids_full_r9: assert (base.diag_main && base.diag_anti && !base.centre);
        end
    end

endmodule

// File: rtl/dice_dot_driver.sv
module dice_dot_driver
    import dice_pkg::*;
(
    input  base_t                base,
    output logic [NUM_DOTS-1:0]  dots
);

    always_comb begin
        dots         = '0;
        dots[DOT_CC] = base.centre;
        dots[DOT_LT] = base.diag_main;
        dots[DOT_RB] = base.diag_main;
        dots[DOT_LB] = base.diag_anti;
        dots[DOT_RT] = base.diag_anti;
        dots[DOT_LM] = base.mids;
        dots[DOT_RM] = base.mids;
    end

endmodule

// File: rtl/dice_roller_top.sv
module dice_roller_top
    import dice_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 roll_i,
    output logic [NUM_DOTS-1:0]  dots_o,
    output logic [FACE_W-1:0]    face_o,
    output logic                 valid_o
);

    ring_t state;
    base_t base;
    logic  valid_q;

    dice_ring_counter u_ring (
        .clk   (clk),
        .rst   (rst),
        .run   (roll_i),
        .state (state)
    );

    dice_base_decode u_decode (
        .state (state),
        .base  (base)
    );

    dice_dot_driver u_dots (
        .base (base),
        .dots (dots_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else begin
            valid_q <= ~roll_i;
        end
    end

    assign valid_o = valid_q;
    assign face_o  = ring_face(state);

    // R4: valid follows the roll input one edge later
    p_valid_up_r4: assert property (@(posedge clk) disable iff (rst)
        !roll_i |=> valid_o);
    p_valid_down_r4: assert property (@(posedge clk) disable iff (rst)
        roll_i |=> !valid_o);

    // R5: a finished roll shows as many dots as its face value
    p_dot_count_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> ($countones(dots_o) == int'(face_o)));

    // R1: reset puts face 6 up on the next edge
    p_reset_face_r1: assert property (@(posedge clk)
        rst |=> (face_o == 3'd6));

endmodule

// File: tb/dice_roller_tb.sv
module dice_roller_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       roll_i = 1'b0;
    logic [6:0] dots_o;
    logic [2:0] face_o;
    logic       valid_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // bench model
    int m_idx   = 0;
    bit m_valid = 1'b0;

    always #2 clk = ~clk;

    dice_roller_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .roll_i  (roll_i),
        .dots_o  (dots_o),
        .face_o  (face_o),
        .valid_o (valid_o)
    );

    function automatic int face_at(input int idx);
        case (idx % 6)
            0: return 6;
            1: return 4;
            2: return 2;
            3: return 1;
            4: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic logic [6:0] dots_for(input int f);
        logic [6:0] d;
        d    = '0;
        d[6] = (f % 2) == 1;                // R6
        d[0] = (f != 1);  d[5] = (f != 1);  // R7
        d[2] = (f >= 4);  d[3] = (f >= 4);  // R8
        d[1] = (f == 6);  d[4] = (f == 6);  // R9
        return d;
    endfunction

    task automatic check_all(input string req);
        int f;
        f = face_at(m_idx);
        n_checks++;
        if (int'(face_o) != f || dots_o != dots_for(f) || valid_o != m_valid) begin
            n_fails++;
            $display("FAIL %s: face=%0d dots=%b valid=%b expected face=%0d dots=%b valid=%b",
                     req, face_o, dots_o, valid_o, f, dots_for(f), m_valid);
        end
    endtask

    task automatic cycle(input bit r, input bit ro);
        @(negedge clk);
        rst    = r;
        roll_i = ro;
        @(posedge clk);
        #1;
        if (r) begin
            m_idx = 0; m_valid = 1'b0;
        end else if (ro) begin
            m_idx = (m_idx + 1) % 6; m_valid = 1'b0;
        end else begin
            m_valid = 1'b1;
        end
    endtask

    task automatic t_reset();
        cycle(1'b1, 1'b0);
        check_all("R1 reset state");
        cycle(1'b0, 1'b0);
        check_all("R4 valid after idle edge");
    endtask

    task automatic t_roll(input int steps);
        for (int i = 0; i < steps; i++) begin
            cycle(1'b0, 1'b1);
            check_all("R2 step in roll order");
        end
    endtask

    task automatic t_release(input int holds);
        cycle(1'b0, 1'b0);
        check_all("R4 valid rises at release");
        for (int i = 0; i < holds; i++) begin
            cycle(1'b0, 1'b0);
            check_all("R3 result held");
        end
    endtask

    task automatic t_every_face();
        // R6 R7 R8 R9 R5: each face shown once, held and checked
        for (int k = 0; k < 6; k++) begin
            cycle(1'b0, 1'b1);
            check_all("R5 face code during roll");
            cycle(1'b0, 1'b0);
            check_all("R6 R7 R8 R9 dot groups");
        end
    endtask

    task automatic t_reset_vs_roll();
        t_roll(3);
        cycle(1'b1, 1'b1);
        check_all("R1 reset wins over roll");
        cycle(1'b0, 1'b1);
        check_all("R2 step after reset");
        t_release(1);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_roll(1);
        t_release(3);
        t_roll(7);
        t_release(2);
        t_every_face();
        t_roll(12);
        t_release(1);
        t_reset_vs_roll();
        t_roll(5);
        t_release(4);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule